// File: doc/BRIEF.md
# Low-Frequency Timer with Watchdog Mode

This block is a 16-bit counter that runs from a slow reference tick, such as one from a 32.768 kHz source, which arrives as a one-cycle enable pulse on the system clock. It can act as a general-purpose timer that counts up or down. As a timer it either wraps through the full range or reloads from a programmable load value. It can also act as a watchdog. In that case it always counts down, and reaching its end raises either a held interrupt or a one-cycle reset request. A prescaler can slow the tick by 16 or by 256. An optional freeze holds the count while the peripheral power-down input is high.

Software uses four word registers on a small write/read bus. The registers are load, current value, control and clear. Writing the clear register restarts the count from the load value and drops a pending interrupt. In watchdog mode that write is the periodic refresh. Once watchdog mode is turned on, the control register is locked until the next system reset.

Top module: `lf_timer_wdog`

## Requirements
- R1: After reset the control, load and value registers all read 0x0000, `irq` and `wdog_rst` are low, and the watchdog lock is released.
- R2: Control fields are: bit 8 up (1) / down (0); bit 7 enable; bit 6 periodic (1) / free-running (0); bit 5 watchdog; bits 3:2 prescale select; bit 1 interrupt-instead-of-reset; bit 0 freeze on power-down. Bits 15:9 and bit 4 are not stored and read as 0.
- R3: The bus addresses are 0 for load, 1 for value (read only), 2 for control and 3 for clear (write only, reads 0). A write to load also sets the value to the written data.
- R4: Counting down in periodic mode, a count step taken while the value is 0 reloads the load value and sets `irq`.
- R5: Counting up in periodic mode, a count step taken while the value is 0xFFFF reloads the load value and sets `irq`.
- R6: In free-running mode the value wraps (0 to 0xFFFF going down, 0xFFFF to 0 going up), and the wrap sets `irq`.
- R7: While bit 7 is clear, reference ticks leave the value unchanged.
- R8: Prescale select 00 or 11 steps on every tick, 01 on every 16th tick and 10 on every 256th tick. The tick count restarts from zero while the timer is disabled.
- R9: With bit 0 set and `pdown` high, ticks leave the value unchanged. With bit 0 clear, `pdown` has no effect.
- R10: `irq` is a level that stays high until a clear write. A clear write drops `irq` and reloads the value from the load register.
- R11: When a clear write falls in the same cycle as an end-of-count step, the clear wins: the value takes the load value, and neither `irq` nor `wdog_rst` is raised.
- R12: In watchdog mode the counter counts down whatever bit 8 holds, and control writes are ignored until reset. With bit 1 set, the end of count sets `irq` and reloads.
- R13: In watchdog mode with bit 1 clear, the end of count drives `wdog_rst` high for exactly one clock and does not set `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high system reset |
| lf_tick | input | 1 | One-cycle pulse per period of the slow reference |
| pdown | input | 1 | Peripheral power-down indication |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` (combinational) |
| irq | output | 1 | Timeout interrupt level |
| wdog_rst | output | 1 | One-cycle watchdog reset request |

## Verification
The sensitive case is a refresh write to the clear register that lands in the same clock as the count step that would end the count. The bench first runs the counter down to its end value. It then drives the clear write and a reference tick together in one cycle, once as a general timer and once in watchdog mode. It judges the result by the value register holding the load value, with `irq` and `wdog_rst` both low. Without the clear, the same step would have wrapped or reloaded and raised the timeout, so either outcome is clearly told apart.

// File: rtl/lftw_pkg.sv
package lftw_pkg;

    localparam int CNT_W  = 16;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        A_LOAD  = 2'd0,
        A_VALUE = 2'd1,
        A_CTRL  = 2'd2,
        A_CLEAR = 2'd3
    } reg_addr_e;

    typedef enum logic [1:0] {
        PS_1   = 2'b00,
        PS_16  = 2'b01,
        PS_256 = 2'b10,
        PS_RSV = 2'b11
    } psel_e;

    typedef struct packed {
        logic [6:0] rsv_hi;
        logic       up;
        logic       en;
        logic       periodic;
        logic       wd;
        logic       rsv4;
        psel_e      psel;
        logic       irq_sel;
        logic       freeze;
    } ctrl_t;

    localparam logic [15:0] CTRL_WMASK = 16'h01EF;

    function automatic ctrl_t ctrl_filter(input logic [15:0] w);
        return ctrl_t'(w & CTRL_WMASK);
    endfunction

    function automatic logic counts_down(input logic wd, input logic up);
        return wd || !up;
    endfunction

endpackage

// File: rtl/lftw_regs.sv
module lftw_regs
    import lftw_pkg::*;
#(
    parameter int DW = CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       wdata,
    output ctrl_t             ctrl_q,
    output logic [DW-1:0]     load_q,
    output logic              ld_wr,
    output logic              clr_wr
);

    logic ctrl_wr;

    always_comb begin
        ld_wr   = wr && (reg_addr_e'(addr) == A_LOAD);
        clr_wr  = wr && (reg_addr_e'(addr) == A_CLEAR);
        ctrl_wr = wr && (reg_addr_e'(addr) == A_CTRL) && !ctrl_q.wd;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= ctrl_t'('0);
            load_q <= '0;
        end else begin
            if (ctrl_wr) ctrl_q <= ctrl_filter(wdata);
            if (ld_wr)   load_q <= wdata[DW-1:0];
        end
    end

endmodule

// File: rtl/lftw_prescaler.sv
module lftw_prescaler
    import lftw_pkg::*;
#(
    parameter int DIV_A_LOG = 4,
    parameter int DIV_B_LOG = 8
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  run,
    input  logic  restart,
    input  logic  tick,
    input  psel_e psel,
    output logic  step
);

    localparam int PW = (DIV_B_LOG > DIV_A_LOG) ? DIV_B_LOG : DIV_A_LOG;

    logic [PW-1:0] pcnt_q;
    logic          live;
    logic          wrap_a;
    logic          wrap_b;

    always_comb begin
        live   = run && tick;
        wrap_a = &pcnt_q[DIV_A_LOG-1:0];
        wrap_b = &pcnt_q[DIV_B_LOG-1:0];
        unique case (psel)
            PS_16:   step = live && wrap_a;
            PS_256:  step = live && wrap_b;
            default: step = live;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || restart) pcnt_q <= '0;
        else if (live)      pcnt_q <= pcnt_q + 1'b1;
    end

endmodule

// File: rtl/lftw_core.sv
module lftw_core
    import lftw_pkg::*;
#(
    parameter int DW = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step,
    input  logic          down,
    input  logic          reload_at_end,
    input  logic          rst_mode,
    input  logic          ld_wr,
    input  logic [DW-1:0] ld_data,
    input  logic          clr_wr,
    input  logic [DW-1:0] load_q,
    output logic [DW-1:0] count_q,
    output logic          irq,
    output logic          wdog_rst
);

    logic          at_end;
    logic          end_evt;
    logic [DW-1:0] count_d;

    always_comb begin
        at_end  = down ? (count_q == '0) : (count_q == '1);
        end_evt = step && at_end && !clr_wr;
        count_d = count_q;
        if (ld_wr)                         count_d = ld_data;
        else if (clr_wr)                   count_d = load_q;
        else if (step && at_end && reload_at_end) count_d = load_q;
        else if (step)                     count_d = down ? count_q - 1'b1 : count_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q  <= '0;
            irq      <= 1'b0;
            wdog_rst <= 1'b0;
        end else begin
            count_q  <= count_d;
            wdog_rst <= end_evt && rst_mode;
            if (clr_wr)                    irq <= 1'b0;
            else if (end_evt && !rst_mode) irq <= 1'b1;
        end
    end

endmodule

// File: rtl/lf_timer_wdog.sv
module lf_timer_wdog
    import lftw_pkg::*;
#(
    parameter int DIV_A_LOG = 4,
    parameter int DIV_B_LOG = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lf_tick,
    input  logic              pdown,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata,
    output logic              irq,
    output logic              wdog_rst
);

    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] load_q;
    logic [CNT_W-1:0] count_q;
    logic             ld_wr;
    logic             clr_wr;
    logic             run;
    logic             step;

    lftw_regs #(.DW(CNT_W)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr     (bus_wr),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .ctrl_q (ctrl_q),
        .load_q (load_q),
        .ld_wr  (ld_wr),
        .clr_wr (clr_wr)
    );

    assign run = ctrl_q.en && !(ctrl_q.freeze && pdown);

    lftw_prescaler #(.DIV_A_LOG(DIV_A_LOG), .DIV_B_LOG(DIV_B_LOG)) u_presc (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .restart (!ctrl_q.en),
        .tick    (lf_tick),
        .psel    (ctrl_q.psel),
        .step    (step)
    );

    lftw_core #(.DW(CNT_W)) u_core (
        .clk           (clk),
        .rst           (rst),
        .step          (step),
        .down          (counts_down(ctrl_q.wd, ctrl_q.up)),
        .reload_at_end (ctrl_q.periodic || ctrl_q.wd),
        .rst_mode      (ctrl_q.wd && !ctrl_q.irq_sel),
        .ld_wr         (ld_wr),
        .ld_data       (bus_wdata[CNT_W-1:0]),
        .clr_wr        (clr_wr),
        .load_q        (load_q),
        .count_q       (count_q),
        .irq           (irq),
        .wdog_rst      (wdog_rst)
    );

    always_comb begin
        unique case (reg_addr_e'(bus_addr))
            A_LOAD:  bus_rdata = load_q;
            A_VALUE: bus_rdata = count_q;
            A_CTRL:  bus_rdata = ctrl_q;
            default: bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/lftw_checker.sv
module lftw_checker
    import lftw_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input ctrl_t             ctrl,
    input logic [15:0]       count,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              pdown,
    input logic              irq,
    input logic              wdog_rst
);

    logic touch_cnt;
    assign touch_cnt = bus_wr && (bus_addr == A_LOAD || bus_addr == A_CLEAR);

    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        (ctrl & ~CTRL_WMASK) == 16'h0);

    a_r7_disabled_hold: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.en && !touch_cnt) |=> $stable(count));

    a_r9_freeze_hold: assert property (@(posedge clk) disable iff (rst)
        (ctrl.freeze && pdown && !touch_cnt) |=> $stable(count));

    a_r10_clear_drops_irq: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == A_CLEAR) |=> !irq);

    a_r12_ctrl_locked: assert property (@(posedge clk) disable iff (rst)
        ctrl.wd |=> $stable(ctrl));

    a_r13_one_cycle: assert property (@(posedge clk) disable iff (rst)
        wdog_rst |=> !wdog_rst);

    a_r13_only_reset_mode: assert property (@(posedge clk) disable iff (rst)
        wdog_rst |-> $past(ctrl.wd && !ctrl.irq_sel));

endmodule

bind lf_timer_wdog lftw_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .ctrl     (ctrl_q),
    .count    (count_q),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .pdown    (pdown),
    .irq      (irq),
    .wdog_rst (wdog_rst)
);

// File: tb/test_lf_timer_wdog.sv
module test_lf_timer_wdog;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lf_tick = 1'b0;
    logic        pdown = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic        irq;
    logic        wdog_rst;

    localparam logic [1:0] AL = 2'd0, AV = 2'd1, AC = 2'd2, AX = 2'd3;

    always #10 clk = ~clk;

    lf_timer_wdog i_lf_timer_wdog (
        .clk(clk), .rst(rst), .lf_tick(lf_tick), .pdown(pdown),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq), .wdog_rst(wdog_rst)
    );

    typedef struct {
        int          src;
        logic [15:0] exp;
        string       tag;
    } item_t;

    item_t q[$];
    event  chk_ev;
    int    checks = 0;
    int    errors = 0;
    bit    done = 0;

    // monitor: pops expected items and compares with the outputs
    initial begin
        forever begin
            @(chk_ev);
            while (q.size() > 0) begin
                item_t it;
                logic [15:0] act;
                it = q.pop_front();
                case (it.src)
                    0:       act = bus_rdata;
                    1:       act = {15'h0, irq};
                    default: act = {15'h0, wdog_rst};
                endcase
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic push(input int src, input logic [15:0] e, input string tag);
        item_t it;
        #1;
        it.src = src; it.exp = e; it.tag = tag;
        q.push_back(it);
        -> chk_ev;
        #1;
    endtask

    task automatic look_rd(input logic [1:0] a, input logic [15:0] e, input string tag);
        bus_addr = a;
        push(0, e, tag);
    endtask

    task automatic look_irq(input logic e, input string tag);
        push(1, {15'h0, e}, tag);
    endtask

    task automatic look_rst(input logic e, input string tag);
        push(2, {15'h0, e}, tag);
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic wr_tick(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; lf_tick = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; lf_tick = 1'b0;
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            lf_tick = 1'b1;
            @(negedge clk);
            lf_tick = 1'b0;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finished");
            finish_run();
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        look_rd(AC, 16'h0000, "R1 ctrl");
        look_rd(AL, 16'h0000, "R1 load");
        look_rd(AV, 16'h0000, "R1 value");
        look_irq(1'b0, "R1 irq");
        look_rst(1'b0, "R1 wdog_rst");

        // R2 reserved bits
        wr(AC, 16'hFE10);
        look_rd(AC, 16'h0000, "R2 reserved read zero");

        // R3 load copies into value, clear reads zero
        wr(AL, 16'h0005);
        look_rd(AV, 16'h0005, "R3 load sets value");
        look_rd(AX, 16'h0000, "R3 clear reads zero");

        // R4 down periodic
        wr(AC, 16'h00C0);
        look_rd(AC, 16'h00C0, "R2 ctrl fields");
        tick(5);
        look_rd(AV, 16'h0000, "R4 down to zero");
        look_irq(1'b0, "R4 no irq yet");
        tick(1);
        look_rd(AV, 16'h0005, "R4 reload");
        look_irq(1'b1, "R4 irq");
        wr(AX, 16'h0);
        look_irq(1'b0, "R10 clear drops irq");
        look_rd(AV, 16'h0005, "R10 clear reloads");

        // R6 up free-running wrap
        wr(AC, 16'h0180);
        wr(AL, 16'hFFFE);
        tick(1);
        look_rd(AV, 16'hFFFF, "R6 up step");
        tick(1);
        look_rd(AV, 16'h0000, "R6 up wrap");
        look_irq(1'b1, "R6 wrap irq");
        tick(1);
        look_irq(1'b1, "R10 irq held");
        wr(AX, 16'h0);
        look_rd(AV, 16'hFFFE, "R10 clear reload");

        // R5 up periodic
        wr(AC, 16'h01C0);
        wr(AL, 16'hFFFD);
        tick(2);
        look_rd(AV, 16'hFFFF, "R5 at top");
        look_irq(1'b0, "R5 no irq yet");
        tick(1);
        look_rd(AV, 16'hFFFD, "R5 reload");
        look_irq(1'b1, "R5 irq");
        wr(AX, 16'h0);

        // R6 down free-running wrap
        wr(AC, 16'h0080);
        wr(AL, 16'h0001);
        tick(2);
        look_rd(AV, 16'hFFFF, "R6 down wrap");
        look_irq(1'b1, "R6 down irq");
        wr(AX, 16'h0);

        // R7 disabled
        wr(AC, 16'h0000);
        tick(3);
        look_rd(AV, 16'h0001, "R7 disabled hold");

        // R9 freeze
        wr(AC, 16'h0081);
        wr(AL, 16'h000A);
        pdown = 1'b1;
        tick(3);
        look_rd(AV, 16'h000A, "R9 frozen");
        pdown = 1'b0;
        tick(1);
        look_rd(AV, 16'h0009, "R9 thawed");
        wr(AC, 16'h0080);
        pdown = 1'b1;
        tick(1);
        look_rd(AV, 16'h0008, "R9 freeze off ignores pdown");
        pdown = 1'b0;

        // R11 timer mode collision
        wr(AL, 16'h0001);
        tick(1);
        look_rd(AV, 16'h0000, "R11 setup");
        wr_tick(AX, 16'h0);
        look_rd(AV, 16'h0001, "R11 clear wins value");
        look_irq(1'b0, "R11 clear wins irq");

        // R8 prescaler
        wr(AC, 16'h0000);
        wr(AL, 16'h000A);
        wr(AC, 16'h0084);
        tick(15);
        look_rd(AV, 16'h000A, "R8 div16 before");
        tick(1);
        look_rd(AV, 16'h0009, "R8 div16 step");
        wr(AC, 16'h0000);
        wr(AL, 16'h000A);
        wr(AC, 16'h0088);
        tick(255);
        look_rd(AV, 16'h000A, "R8 div256 before");
        tick(1);
        look_rd(AV, 16'h0009, "R8 div256 step");
        wr(AC, 16'h0000);
        wr(AL, 16'h000A);
        wr(AC, 16'h008C);
        tick(1);
        look_rd(AV, 16'h0009, "R8 sel11 div1");

        // R12 watchdog with interrupt
        wr(AC, 16'h0000);
        wr(AL, 16'h0002);
        wr(AC, 16'h00A2);
        tick(2);
        look_rd(AV, 16'h0000, "R12 wd down");
        tick(1);
        look_rd(AV, 16'h0002, "R12 wd reload");
        look_irq(1'b1, "R12 wd irq");
        look_rst(1'b0, "R12 no reset pulse");
        wr(AC, 16'h0000);
        look_rd(AC, 16'h00A2, "R12 ctrl locked");
        wr(AX, 16'h0);
        look_irq(1'b0, "R10 kick drops irq");
        look_rd(AV, 16'h0002, "R10 kick reload");
        tick(2);
        wr_tick(AX, 16'h0);
        look_rd(AV, 16'h0002, "R11 wd clear wins value");
        look_irq(1'b0, "R11 wd clear wins irq");
        look_rst(1'b0, "R11 wd clear wins rst");

        // R1 reset releases lock, R13 reset pulse
        do_reset();
        look_rd(AC, 16'h0000, "R1 lock released");
        wr(AL, 16'h0001);
        wr(AC, 16'h01A0);
        tick(1);
        look_rd(AV, 16'h0000, "R12 wd ignores up bit");
        tick(1);
        look_rst(1'b1, "R13 reset pulse");
        look_irq(1'b0, "R13 no irq");
        @(negedge clk);
        look_rst(1'b0, "R13 pulse one cycle");

        @(negedge clk);
        done = 1;
        finish_run();
    end

endmodule